// File: doc/BRIEF.md
# Serial Baud Tick Generator

This block turns a programmable 16-bit clock divisor into two single-cycle enables for a serial port: an oversampling tick and a bit tick. The receive and transmit shifters that sit beside it use the oversampling tick to place their sampling points, and they use the bit tick to step from one bit to the next. A register interface writes a new divisor by driving the value and pulsing a load strobe. The new rate takes effect in the cycle after the load, and the internal counters restart from zero at that point.

Two divisor values get special treatment. A divisor of zero turns the generator off, so neither tick is produced. A divisor of one skips the oversampling division, so both ticks stay high on every cycle and the bit rate equals the system clock. Any divisor N of two or more produces an oversampling tick every N clocks and a bit tick every 16·N clocks.

Top module: `baud_tick_gen`

## Requirements
- R1: After a synchronous active-low reset, the stored divisor is zero and neither tick is asserted until a divisor is loaded.
- R2: While the stored divisor is zero, `os_tick` and `bit_tick` both stay low on every cycle.
- R3: While the stored divisor is one, `os_tick` and `bit_tick` are both high on every cycle, so the bit tick period is one clock.
- R4: For a stored divisor N ≥ 2, `os_tick` is a one-cycle pulse that repeats every N clocks. Its first pulse falls in the N-th cycle after the clock edge that sampled the load.
- R5: For N ≥ 2, `bit_tick` is a one-cycle pulse that coincides with every 16th `os_tick` (OVS_RATIO = 16). Its first pulse falls in cycle 16·N after the load, and between two bit ticks there are exactly 16 oversampling ticks.
- R6: A load strobe replaces the divisor at once and clears both internal counters. The timing of R4 and R5 is then measured from that load, whatever the generator was doing before.
- R7: The divisor uses its full 16-bit range. With the value 0xFFFF, the first `os_tick` falls in cycle 65535 after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_load | input | 1 | One-cycle strobe that stores `div_value` |
| div_value | input | 16 | New divisor (DIV_W bits) |
| os_tick | output | 1 | Oversampling enable, one clock wide |
| bit_tick | output | 1 | Bit-rate enable, one clock wide |

## Verification
The bench builds the generator with its default parameters: a 16-bit divisor and an oversampling ratio of 16. These are the values the serial port uses. With the full-width divisor, the bench can load 0xFFFF and confirm that the prescaler neither wraps early nor truncates the value. The ratio of 16 gives realistic bit periods, and every small divisor still finishes a complete bit period well inside the run. The bench also reloads a new divisor in the middle of a period, which checks that the counter restart on a load is visible at the tick outputs.

// File: rtl/baud_tick_pkg.sv
// Shared definitions for the baud tick generator.
package baud_tick_pkg;
    // Operating mode decoded from the stored divisor.
    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,  // divisor zero: no ticks
        MODE_BYPASS = 2'd1,  // divisor one: ticks every cycle
        MODE_DIVIDE = 2'd2   // divisor >= 2: prescale then oversample
    } baud_mode_t;
endpackage

// File: rtl/baud_prescaler.sv
// Prescaler: produces one pulse every `div` clocks while `run` is high.
// Assumes div >= 2 whenever run is high; clear restarts the count at zero.
module baud_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic             at_end;

    // Detect the last count of the period.
    always_comb begin
        at_end = (cnt == div - ONE);
    end

    // Count clocks modulo div.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            cnt <= '0;
        end else if (at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    assign tick = run && at_end;

    // R4: the count never reaches the divisor
    a_r4_cnt_below_div: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < div));
    // R4: two pulses never fall in adjacent cycles when div >= 2
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !clear) |=> !tick || clear || $past(clear));
endmodule

// File: rtl/baud_oversampler.sv
// Oversample divider: counts input pulses and flags every OVS_RATIO-th one.
// Assumes os_in is a one-cycle enable; clear restarts the count at zero.
module baud_oversampler #(
    parameter int OVS_RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic os_in,
    output logic bit_out
);
    localparam int OW = (OVS_RATIO > 1) ? $clog2(OVS_RATIO) : 1;
    localparam logic [OW-1:0] LAST = OW'(OVS_RATIO - 1);

    logic [OW-1:0] ocnt;

    // Advance once per oversampling pulse, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ocnt <= '0;
        end else if (os_in) begin
            ocnt <= (ocnt == LAST) ? '0 : ocnt + OW'(1);
        end
    end

    assign bit_out = os_in && (ocnt == LAST);

    // R5: the counter stays inside the ratio
    a_r5_ocnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ocnt <= LAST);
    // R5: the count only moves on an oversampling pulse or a clear
    a_r5_ocnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_in && !clear) |=> $stable(ocnt));
endmodule

// File: rtl/baud_tick_gen.sv
// Baud tick generator top: stores the divisor, decodes the mode and combines
// the prescaler and oversample stages. Assumes div_load is a single-cycle strobe.
module baud_tick_gen #(
    parameter int DIV_W     = 16,
    parameter int OVS_RATIO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_value,
    output logic             os_tick,
    output logic             bit_tick
);
    import baud_tick_pkg::*;

    logic [DIV_W-1:0] div_q;
    logic             clr_q;
    baud_mode_t       mode;
    logic             pre_tick;
    logic             ovs_bit;

    // Hold the divisor and a one-cycle restart flag after each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= div_load;
            if (div_load) begin
                div_q <= div_value;
            end
        end
    end

    // Decode the operating mode from the stored divisor.
    always_comb begin
        if (div_q == '0) begin
            mode = MODE_OFF;
        end else if (div_q == DIV_W'(1)) begin
            mode = MODE_BYPASS;
        end else begin
            mode = MODE_DIVIDE;
        end
    end

    baud_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (div_load),
        .run   (mode == MODE_DIVIDE),
        .div   (div_q),
        .tick  (pre_tick)
    );

    baud_oversampler #(.OVS_RATIO(OVS_RATIO)) u_ovs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (div_load),
        .os_in   (pre_tick),
        .bit_out (ovs_bit)
    );

    // Select the tick outputs for the current mode.
    always_comb begin
        case (mode)
            MODE_BYPASS: begin
                os_tick  = 1'b1;
                bit_tick = 1'b1;
            end
            MODE_DIVIDE: begin
                os_tick  = pre_tick;
                bit_tick = ovs_bit;
            end
            default: begin
                os_tick  = 1'b0;
                bit_tick = 1'b0;
            end
        endcase
    end

    // R2: a zero divisor keeps both ticks low
    a_r2_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0) |-> (!os_tick && !bit_tick));
    // R3: a divisor of one keeps both ticks high
    a_r3_bypass_high: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == DIV_W'(1)) |-> (os_tick && bit_tick));
    // R5: a bit tick always coincides with an oversampling tick
    a_r5_bit_in_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
    // R6: after loading a divisor of 3 or more, no tick in the first cycle
    a_r6_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q && div_q > DIV_W'(2)) |-> (!os_tick && !bit_tick));
endmodule

// File: tb/sim_baud_tick_gen.sv
// Self-checking bench for baud_tick_gen.
module sim_baud_tick_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 16;
    localparam int OVS = 16;
    localparam int WATCHDOG = 190000;
    localparam int NV = 5;
    // {divisor, first os cycle, first bit cycle, bit period, os per bit}
    localparam int VEC [NV][5] = '{
        '{2, 2, 32, 32, 16},
        '{3, 3, 48, 48, 16},
        '{5, 5, 80, 80, 16},
        '{1, 1, 1, 1, 1},
        '{7, 7, 112, 112, 16}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             div_load = 1'b0;
    logic [DIV_W-1:0] div_value = '0;
    logic             os_tick;
    logic             bit_tick;
    int               total = 0;
    int               bad = 0;
    int               cycles = 0;
    bit               done = 1'b0;

    baud_tick_gen #(.DIV_W(DIV_W), .OVS_RATIO(OVS)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_load  (div_load),
        .div_value (div_value),
        .os_tick   (os_tick),
        .bit_tick  (bit_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe a divisor; returns at the negedge of cycle 1 after the load edge.
    task automatic load_div(input int d);
        @(negedge clk);
        div_load = 1'b1;
        div_value = DIV_W'(d);
        @(negedge clk);
        div_load = 1'b0;
    endtask

    // Measure tick timing from cycle 1 onward (caller is at the cycle-1 negedge).
    task automatic measure(input int limit, output int f_os, output int f_bit,
                           output int per, output int os_between);
        int bits_seen;
        f_os = 0; f_bit = 0; per = 0; os_between = 0; bits_seen = 0;
        for (int c = 1; c <= limit; c++) begin
            if (bits_seen == 1 && os_tick) os_between++;
            if (os_tick && f_os == 0) f_os = c;
            if (bit_tick) begin
                if (bits_seen == 0) f_bit = c;
                else if (bits_seen == 1) per = c - f_bit;
                bits_seen++;
            end
            if (bits_seen >= 2) break;
            @(negedge clk);
        end
    endtask

    // Count ticks over a number of cycles.
    task automatic count_ticks(input int n, output int n_os, output int n_bit);
        n_os = 0; n_bit = 0;
        for (int c = 0; c < n; c++) begin
            if (os_tick) n_os++;
            if (bit_tick) n_bit++;
            @(negedge clk);
        end
    endtask

    initial begin
        int fo, fb, pr, ob, no, nb;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        count_ticks(40, no, nb);
        check("R1 os after reset", no, 0);
        check("R1 bit after reset", nb, 0);

        // Table of vectors: R3, R4, R5
        for (int i = 0; i < NV; i++) begin
            load_div(VEC[i][0]);
            measure(2 * VEC[i][2] + 8, fo, fb, pr, ob);
            check(VEC[i][0] == 1 ? "R3 first os" : "R4 first os", fo, VEC[i][1]);
            check(VEC[i][0] == 1 ? "R3 first bit" : "R5 first bit", fb, VEC[i][2]);
            check(VEC[i][0] == 1 ? "R3 bit period" : "R5 bit period", pr, VEC[i][3]);
            check(VEC[i][0] == 1 ? "R3 os per bit" : "R5 os per bit", ob, VEC[i][4]);
        end

        // R3: divisor one holds both ticks for a long stretch
        load_div(1);
        count_ticks(50, no, nb);
        check("R3 os every cycle", no, 50);
        check("R3 bit every cycle", nb, 50);

        // R2: divisor zero stops a running generator
        load_div(4);
        repeat (30) @(negedge clk);
        load_div(0);
        count_ticks(200, no, nb);
        check("R2 os stopped", no, 0);
        check("R2 bit stopped", nb, 0);

        // R4: exact os count over whole periods with N=6
        load_div(6);
        count_ticks(6 * 20, no, nb);
        check("R4 os count N=6", no, 20);
        check("R5 bit count N=6", nb, 1);

        // R6: reload mid-period restarts both counters
        load_div(4);
        repeat (37) @(negedge clk);
        load_div(3);
        measure(120, fo, fb, pr, ob);
        check("R6 first os after reload", fo, 3);
        check("R6 first bit after reload", fb, 48);

        // R6: reloading the same value also restarts the count
        load_div(5);
        repeat (3) @(negedge clk);
        load_div(5);
        measure(200, fo, fb, pr, ob);
        check("R6 same value restart", fo, 5);

        // R7: full-width divisor
        load_div(16'hFFFF);
        fo = 0;
        for (int c = 1; c <= 65600; c++) begin
            if (os_tick) begin fo = c; break; end
            @(negedge clk);
        end
        check("R7 first os at 0xFFFF", fo, 65535);

        done = 1'b1;
    end

    // Finish on completion or on watchdog expiry.
    initial begin
        wait (done || cycles >= WATCHDOG);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule